// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block sits between a CPU with a 16-bit address bus and three kinds of target: a 512K RAM, a 32K EEPROM and a group of I/O peripherals. It turns each bus address into one active-low chip select and a physical address for the selected memory. It also holds an 8-bit paging register, which sits inside the I/O range and has three jobs. It places any 32K page of the RAM in the low half of the CPU map. It picks which 4K bank of the EEPROM appears at the top of the map. It drives an active-low status LED.

The RAM between 0x8000 and 0xDFFF always comes from physical page 1, whatever the register holds. Software that changes pages can therefore run there safely. Loading page 1 into the register makes the low window mirror that fixed bank. This gives access to the RAM that lies under the I/O and EEPROM overlay.

The register captures the data bus on every strobed access to its address, and it ignores the read/write line. A read-modify-write sequence aimed at it can therefore leave arbitrary data behind. A parameter can restrict loading to write cycles, but the default keeps the unqualified behaviour.

Top module: `pgmap_decoder`

## Requirements
- R1: After reset the paging register holds 0x00: the low window shows RAM page 0, EEPROM bank 0 is selected and `led_n` is 0 (LED lit).
- R2: A strobed access in 0x0000-0x7FFF pulls `ram_cs_n` low, with `ram_addr` = {register bits 3..0, cpu_addr bits 14..0}.
- R3: A strobed access in 0x8000-0xDFFF pulls `ram_cs_n` low, with `ram_addr` = {4'b0001, cpu_addr bits 14..0}, whatever the register holds.
- R4: A strobed access in 0xE000-0xEFFF pulls only `io_cs_n` low. This includes the register address 0xEF00.
- R5: A strobed access in 0xF000-0xFFFF pulls only `rom_cs_n` low. `rom_addr` is {register bits 6..4, cpu_addr bits 11..0}.
- R6: `led_n` equals register bit 7: 1 turns the LED off and 0 turns it on.
- R7: On a clock edge with `bus_strobe` high and `cpu_addr` = 0xEF00, the register takes `cpu_data`. This happens for reads (`cpu_rw`=1) and writes (`cpu_rw`=0) alike. The new value takes effect in the cycle after that edge.
- R8: The register keeps its value when `bus_strobe` is low, and when the address differs from 0xEF00 (for example 0xEF01 or 0x6F00).
- R9: While `bus_strobe` is high, exactly one of `ram_cs_n`, `rom_cs_n` and `io_cs_n` is low. While it is low, all three are high.
- R10: With page 1 loaded, a low-window address X and the address X+0x8000 produce the same `ram_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_strobe | input | 1 | High during a valid bus cycle |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU data bus, as seen by the paging register |
| ram_addr | output | 19 | Physical RAM address |
| rom_addr | output | 15 | Physical EEPROM address |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | EEPROM select, active low |
| io_cs_n | output | 1 | I/O select, active low |
| led_n | output | 1 | Status LED drive, active low |

## Verification
The selects, `ram_addr` and `rom_addr` follow the address and strobe with no register in between, so they are due in the same cycle as the stimulus. The bench drives inputs at the falling edge and compares a quarter period later. A load of the paging register shows up on the outputs only after the next rising edge. The bench's reference model therefore updates its register copy just after that edge, and the following cycle is the first one compared against the new page, bank and LED values. The internal reset synchronizer holds the block in reset for two edges after `rst_n` rises, and the bench keeps the strobe low during that time.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  typedef enum logic [1:0] {
    RGN_LOW_WINDOW = 2'd0,
    RGN_UPPER_RAM  = 2'd1,
    RGN_IO         = 2'd2,
    RGN_ROM        = 2'd3
  } region_e;

  localparam int unsigned DEF_ADDR_W    = 16;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_PAGE_BITS = 4;
  localparam int unsigned DEF_BANK_BITS = 3;

endpackage

// File: rtl/pgmap_rst_sync.sv
module pgmap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage1_d;
  logic stage2_d;

  always_comb begin
    stage1_d = 1'b1;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      stage1_q <= stage1_d;
      srst_n   <= stage2_d;
    end
  end

endmodule

// File: rtl/pgmap_latch.sv
module pgmap_latch #(
  parameter int unsigned ADDR_W        = pgmap_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W        = pgmap_pkg::DEF_DATA_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hEF00,
  parameter bit          QUALIFY_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] q
);

  logic              hit;
  logic              load_en;
  logic [DATA_W-1:0] q_next;

  assign hit = strobe && (addr == REG_ADDR);

  generate
    if (QUALIFY_WRITE) begin : g_write_only
      assign load_en = hit && !rw;
    end else begin : g_any_access
      logic unused_rw;
      assign unused_rw = rw;
      assign load_en   = hit;
    end
  endgenerate

  always_comb begin
    q_next = q;
    if (load_en) begin
      q_next = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_next;
    end
  end

  // R7: a strobed access to the register address loads the data bus
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && addr == REG_ADDR && (!QUALIFY_WRITE || !rw)) |=> (q == $past(data)));

  // R8: any other cycle leaves the register alone
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe || addr != REG_ADDR) |=> $stable(q));

endmodule

// File: rtl/pgmap_region.sv
module pgmap_region
  import pgmap_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output region_e           region,
  output logic              ram_cs_n,
  output logic              io_cs_n,
  output logic              rom_cs_n
);

  localparam int unsigned NIB_LSB = ADDR_W - 4;

  logic [3:0] top_nib;

  assign top_nib = addr[ADDR_W-1:NIB_LSB];

  always_comb begin
    if (!top_nib[3]) begin
      region = RGN_LOW_WINDOW;
    end else if (top_nib == 4'hE) begin
      region = RGN_IO;
    end else if (top_nib == 4'hF) begin
      region = RGN_ROM;
    end else begin
      region = RGN_UPPER_RAM;
    end
  end

  always_comb begin
    ram_cs_n = 1'b1;
    io_cs_n  = 1'b1;
    rom_cs_n = 1'b1;
    if (strobe) begin
      unique case (region)
        RGN_LOW_WINDOW, RGN_UPPER_RAM: ram_cs_n = 1'b0;
        RGN_IO:                        io_cs_n  = 1'b0;
        RGN_ROM:                       rom_cs_n = 1'b0;
        default:                       ram_cs_n = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
  import pgmap_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned PAGE_BITS  = DEF_PAGE_BITS,
  parameter int unsigned BANK_BITS  = DEF_BANK_BITS,
  parameter int unsigned UPPER_PAGE = 1,
  localparam int unsigned WIN_BITS  = ADDR_W - 1,
  localparam int unsigned OFF_BITS  = ADDR_W - 4,
  localparam int unsigned RAM_AW    = PAGE_BITS + WIN_BITS,
  localparam int unsigned ROM_AW    = BANK_BITS + OFF_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  input  region_e              region,
  input  logic [PAGE_BITS-1:0] page,
  input  logic [BANK_BITS-1:0] bank,
  output logic [RAM_AW-1:0]    ram_addr,
  output logic [ROM_AW-1:0]    rom_addr
);

  localparam logic [PAGE_BITS-1:0] FIXED_PAGE = PAGE_BITS'(UPPER_PAGE);

  logic [PAGE_BITS-1:0] phys_page;

  always_comb begin
    if (region == RGN_LOW_WINDOW) begin
      phys_page = page;
    end else begin
      phys_page = FIXED_PAGE;
    end
  end

  assign ram_addr = {phys_page, addr[WIN_BITS-1:0]};
  assign rom_addr = {bank, addr[OFF_BITS-1:0]};

endmodule

// File: rtl/pgmap_decoder.sv
module pgmap_decoder
  import pgmap_pkg::*;
#(
  parameter int unsigned ADDR_W        = DEF_ADDR_W,
  parameter int unsigned DATA_W        = DEF_DATA_W,
  parameter int unsigned PAGE_BITS     = DEF_PAGE_BITS,
  parameter int unsigned BANK_BITS     = DEF_BANK_BITS,
  parameter int unsigned UPPER_PAGE    = 1,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hEF00,
  parameter bit          QUALIFY_WRITE = 1'b0,
  localparam int unsigned RAM_AW       = PAGE_BITS + ADDR_W - 1,
  localparam int unsigned ROM_AW       = BANK_BITS + ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              io_cs_n,
  output logic              led_n
);

  localparam int unsigned BANK_LSB = PAGE_BITS;
  localparam int unsigned BANK_MSB = PAGE_BITS + BANK_BITS - 1;
  localparam int unsigned WIN_BITS = ADDR_W - 1;

  logic              srst_n;
  logic [DATA_W-1:0] page_reg;
  region_e           region;

  pgmap_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pgmap_latch #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .REG_ADDR      (REG_ADDR),
    .QUALIFY_WRITE (QUALIFY_WRITE)
  ) u_latch (
    .clk    (clk),
    .rst_n  (srst_n),
    .strobe (bus_strobe),
    .rw     (cpu_rw),
    .addr   (cpu_addr),
    .data   (cpu_data),
    .q      (page_reg)
  );

  pgmap_region #(
    .ADDR_W (ADDR_W)
  ) u_region (
    .addr     (cpu_addr),
    .strobe   (bus_strobe),
    .region   (region),
    .ram_cs_n (ram_cs_n),
    .io_cs_n  (io_cs_n),
    .rom_cs_n (rom_cs_n)
  );

  pgmap_xlate #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .BANK_BITS  (BANK_BITS),
    .UPPER_PAGE (UPPER_PAGE)
  ) u_xlate (
    .addr     (cpu_addr),
    .region   (region),
    .page     (page_reg[PAGE_BITS-1:0]),
    .bank     (page_reg[BANK_MSB:BANK_LSB]),
    .ram_addr (ram_addr),
    .rom_addr (rom_addr)
  );

  assign led_n = page_reg[DATA_W-1];

  // R9: one select per strobed cycle
  a_r9_one_select: assert property (@(posedge clk) disable iff (!srst_n)
    bus_strobe |-> ($countones({ram_cs_n, rom_cs_n, io_cs_n}) == 2));

  // R9: nothing selected between cycles
  a_r9_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_strobe |-> (ram_cs_n && rom_cs_n && io_cs_n));

  // R3: the upper bank ignores the register
  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!srst_n)
    (!ram_cs_n && cpu_addr[ADDR_W-1])
      |-> (ram_addr[RAM_AW-1:WIN_BITS] == PAGE_BITS'(UPPER_PAGE)));

  // R2: the low window follows the register page field
  a_r2_window: assert property (@(posedge clk) disable iff (!srst_n)
    (!ram_cs_n && !cpu_addr[ADDR_W-1])
      |-> (ram_addr[RAM_AW-1:WIN_BITS] == page_reg[PAGE_BITS-1:0]));

  // R4: I/O range never reaches RAM or EEPROM
  a_r4_io_only: assert property (@(posedge clk) disable iff (!srst_n)
    !io_cs_n |-> (ram_cs_n && rom_cs_n));

endmodule

// File: tb/tb_pgmap_decoder.sv
module tb_pgmap_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_strobe;
  logic        cpu_rw;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic [18:0] ram_addr;
  logic [14:0] rom_addr;
  logic        ram_cs_n;
  logic        rom_cs_n;
  logic        io_cs_n;
  logic        led_n;

  int checks = 0;
  int errors = 0;
  int model_reg = 0;
  bit done = 0;
  int lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgmap_decoder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_strobe (bus_strobe),
    .cpu_rw     (cpu_rw),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .ram_addr   (ram_addr),
    .rom_addr   (rom_addr),
    .ram_cs_n   (ram_cs_n),
    .rom_cs_n   (rom_cs_n),
    .io_cs_n    (io_cs_n),
    .led_n      (led_n)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, compare, then advance the model
  task automatic bus(bit stb, bit rw, int addr, int data);
    bit want_ram, want_io, want_rom;
    @(negedge clk);
    bus_strobe = stb;
    cpu_rw     = rw;
    cpu_addr   = addr[15:0];
    cpu_data   = data[7:0];
    #(CLK_PERIOD/4);
    want_ram = stb && (addr < 'hE000);
    want_io  = stb && (addr >= 'hE000) && (addr < 'hF000);
    want_rom = stb && (addr >= 'hF000);
    chk("R9 ram select", int'(ram_cs_n), int'(!want_ram));
    chk(want_io ? "R4 io select" : "R9 io select", int'(io_cs_n), int'(!want_io));
    chk("R9 rom select", int'(rom_cs_n), int'(!want_rom));
    if (want_ram && addr < 'h8000)
      chk("R2 low window address", int'(ram_addr), (model_reg % 16) * 32768 + addr);
    if (want_ram && addr >= 'h8000)
      chk("R3 upper bank address", int'(ram_addr), 32768 + (addr - 32768));
    if (want_rom)
      chk("R5 eeprom address", int'(rom_addr), ((model_reg / 16) % 8) * 4096 + addr % 4096);
    chk("R6 led drive", int'(led_n), model_reg / 128);
    @(posedge clk);
    if (stb && addr == 'hEF00) model_reg = data % 256;
  endtask

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'h00FF_FFFF;
  endfunction

  initial begin
    int lo_a, hi_a;
    rst_n = 1'b0;
    bus_strobe = 1'b0;
    cpu_rw = 1'b1;
    cpu_addr = '0;
    cpu_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) bus(0, 1, 0, 0);

    // R1: reset contents
    bus(1, 1, 'h0123, 0);
    chk("R1 page 0 after reset", int'(ram_addr), 'h0123);
    bus(1, 1, 'hF123, 0);
    chk("R1 bank 0 after reset", int'(rom_addr), 'h0123);
    chk("R1 led on after reset", int'(led_n), 0);

    // R7: write load, visible in the following cycle
    bus(1, 0, 'hEF00, 'h5A);
    bus(1, 1, 'h1234, 0);
    chk("R7 write loaded page", int'(ram_addr), 'h5_1234);
    bus(1, 1, 'hF800, 0);
    chk("R7 write loaded bank", int'(rom_addr), 'h5800);

    // R7: a read also loads
    bus(1, 1, 'hEF00, 'hC3);
    bus(1, 1, 'h0042, 0);
    chk("R7 read loaded page", int'(ram_addr), 'h1_8042);
    chk("R7 read loaded led", int'(led_n), 1);

    // R8: no load without strobe or at other addresses
    bus(0, 0, 'hEF00, 'hFF);
    bus(1, 0, 'hEF01, 'hFF);
    bus(1, 0, 'h6F00, 'hFF);
    bus(1, 1, 'h0042, 0);
    chk("R8 page kept", int'(ram_addr), 'h1_8042);
    bus(1, 1, 'hFFFE, 0);
    chk("R8 bank kept", int'(rom_addr), 'h4FFE);

    // R3: upper bank with all register bits set
    bus(1, 0, 'hEF00, 'hFF);
    bus(1, 1, 'hDFFF, 0);
    chk("R3 upper fixed", int'(ram_addr), 'hDFFF);

    // R6: led control both ways
    bus(1, 0, 'hEF00, 'h80);
    bus(0, 1, 0, 0);
    chk("R6 led off", int'(led_n), 1);
    bus(1, 0, 'hEF00, 'h00);
    bus(0, 1, 0, 0);
    chk("R6 led on", int'(led_n), 0);

    // R10: page 1 mirrors the upper bank
    bus(1, 0, 'hEF00, 'h01);
    bus(1, 1, 'h1234, 0);
    #1 lo_a = int'(ram_addr);
    bus(1, 1, 'h9234, 0);
    #1 hi_a = int'(ram_addr);
    chk("R10 mirror of upper bank", lo_a, hi_a);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int r = next_rand();
      int a = (r % 8 == 0) ? 'hEF00 : (next_rand() % 65536);
      bus((r / 8) % 8 != 0, (r / 64) % 2, a, next_rand() % 256);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule